// File: doc/BRIEF.md
# Masked Condition Evaluator for a Descriptor DMA Channel

This block decides, for the descriptor a DMA sequencer is currently retiring, three things at once: whether to raise an interrupt, whether to take a branch instead of stepping to the following descriptor, and whether to stall. Each decision has its own select register. A select register holds a 4-bit mask and a 4-bit compare value. A condition is true when the low nibble of the channel's device status, masked, equals the compare value under the same mask.

The descriptor's command word carries a 2-bit gating mode per decision. The mode says never, when the condition is true, when it is false, or always. The sequencer writes the select registers through a simple indexed write port. It raises a one-cycle evaluate strobe together with the command word and the device status. One cycle later it receives the registered results. A read port returns the stored mask and value fields so that software-visible state can be checked.

Top module: `dma_cond_eval`

## Requirements
- R1: After a synchronous active-low reset, all result outputs are 0, all three select registers read back as 0, and a zero mask makes every condition true.
- R2: A write to register index 4 (interrupt), 5 (branch) or 6 (wait) stores bits 19:16 of the write data as that unit's mask and bits 3:0 as its compare value. A read of the same index returns exactly those fields in the same positions, with all other bits 0.
- R3: Writes to any other index leave all three select registers unchanged, and a read of any other index returns 0.
- R4: A unit's condition is true when (dev_status[3:0] & mask) equals (value & mask). dev_status bits above 3 have no effect.
- R5: The interrupt mode is command bits 5:4 (0 never, 1 if the condition is true, 2 if it is false, 3 always). irq_pulse is high for exactly the one cycle after an evaluate strobe whose gating passes.
- R6: The branch mode is command bits 3:2, with the same encoding. In the cycle after an evaluate, exactly one of branch_take and step_next is high, and step_next is high when the branch gating fails (including mode 0).
- R7: The wait mode is command bits 1:0, with the same encoding. wait_stall reports the gated wait condition in the cycle after an evaluate.
- R8: result_valid and every result output are high only in the cycle after an evaluate strobe, and low in every other cycle.
- R9: An evaluate uses the select contents held before a write in the same cycle, and the status and command presented in the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_wr_en | input | 1 | Select register write enable |
| sel_wr_idx | input | 4 | Register index of the write |
| sel_wr_data | input | 32 | Write data (mask in 19:16, value in 3:0) |
| sel_rd_idx | input | 4 | Register index for read-back |
| sel_rd_data | output | 32 | Read-back of the stored fields |
| eval_strobe | input | 1 | Evaluate the current descriptor this cycle |
| cmd_word | input | 16 | Descriptor command word |
| dev_status | input | 8 | Channel device status (low nibble used) |
| result_valid | output | 1 | Results below are valid this cycle |
| irq_pulse | output | 1 | One-cycle interrupt request |
| branch_take | output | 1 | Take the branch target |
| step_next | output | 1 | Step to the following descriptor |
| wait_stall | output | 1 | Stall on this descriptor |

## Verification
A wrong mask or value held in a select register cannot be seen as a separate status. It shows up at the read port in the very next cycle, and it also shows in the decision of the next evaluate that uses that unit with a conditional mode. A slip between the three units, such as a swapped mode field or register index, flips a single output one cycle after a strobe. A stuck or missing result register shows as a pulse that lasts too long, or as a result with no strobe before it. The bench compares every output against a behavioural model on every clock, so any of these faults is reported within one cycle of the first stimulus that exposes it.

// File: rtl/dce_pkg.sv
// Shared types for the masked condition evaluator.
// Assumes a fixed nibble-wide condition field and three evaluation units.
package dce_pkg;
    localparam int COND_W  = 4;
    localparam int N_UNITS = 3;

    // Unit order: index 0 interrupt, 1 branch, 2 wait.
    localparam int UNIT_IRQ  = 0;
    localparam int UNIT_BR   = 1;
    localparam int UNIT_WAIT = 2;

    typedef enum logic [1:0] {
        GATE_NEVER    = 2'd0,
        GATE_IF_TRUE  = 2'd1,
        GATE_IF_FALSE = 2'd2,
        GATE_ALWAYS   = 2'd3
    } gate_mode_e;

    typedef struct packed {
        logic [COND_W-1:0] mask;
        logic [COND_W-1:0] value;
    } sel_t;
endpackage

// File: rtl/dce_sel_regs.sv
// Select register file: one mask/value pair per evaluation unit.
// Assumes single-cycle indexed writes with no side effects. Reads are
// combinational and return only the stored fields; all other bits are zero.
module dce_sel_regs
    import dce_pkg::*;
#(
    parameter int ADDR_W       = 4,
    parameter int DATA_W       = 32,
    parameter int MASK_LSB     = 16,
    parameter int VAL_LSB      = 0,
    parameter int IRQ_SEL_IDX  = 4,
    parameter int BR_SEL_IDX   = 5,
    parameter int WAIT_SEL_IDX = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_idx,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_idx,
    output logic [DATA_W-1:0]          rd_data,
    output sel_t [N_UNITS-1:0]         sel_o
);
    localparam int SEL_IDX [N_UNITS] = '{IRQ_SEL_IDX, BR_SEL_IDX, WAIT_SEL_IDX};

    sel_t [N_UNITS-1:0] sel_q;
    logic [N_UNITS-1:0] hit_wr;

    for (genvar u = 0; u < N_UNITS; u++) begin : g_reg
        // Decode whether this write targets unit u.
        assign hit_wr[u] = wr_en && (wr_idx == ADDR_W'(SEL_IDX[u]));

        // Capture mask and value fields on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q[u] <= '0;
            end else if (hit_wr[u]) begin
                sel_q[u].mask  <= wr_data[MASK_LSB +: COND_W];
                sel_q[u].value <= wr_data[VAL_LSB  +: COND_W];
            end
        end
    end

    // Assemble read-back word for the addressed unit.
    always_comb begin
        rd_data = '0;
        for (int u = 0; u < N_UNITS; u++) begin
            if (rd_idx == ADDR_W'(SEL_IDX[u])) begin
                rd_data[MASK_LSB +: COND_W] = sel_q[u].mask;
                rd_data[VAL_LSB  +: COND_W] = sel_q[u].value;
            end
        end
    end

    assign sel_o = sel_q;

    AST_SEL_HOLD_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_wr == '0) |=> $stable(sel_q)); // R3

    AST_SEL_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_wr)); // R2
endmodule

// File: rtl/dce_cond_unit.sv
// One evaluation unit: masked compare of the status nibble against the
// select value, gated by a 2-bit mode. Purely combinational.
module dce_cond_unit
    import dce_pkg::*;
(
    input  sel_t              sel_i,
    input  logic [COND_W-1:0] status_i,
    input  gate_mode_e        mode_i,
    output logic              fire_o
);
    logic match;

    // Compare only the bit positions selected by the mask.
    assign match = ((status_i & sel_i.mask) == (sel_i.value & sel_i.mask));

    // Apply the gating mode to the comparison result.
    always_comb begin
        unique case (mode_i)
            GATE_NEVER:    fire_o = 1'b0;
            GATE_IF_TRUE:  fire_o = match;
            GATE_IF_FALSE: fire_o = !match;
            GATE_ALWAYS:   fire_o = 1'b1;
            default:       fire_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/dma_cond_eval.sv
// Top of the masked condition evaluator. Holds the three select registers,
// runs three evaluation units on an evaluate strobe, and registers the results
// for exactly one cycle. Assumes the sequencer presents command and status
// together with the strobe.
module dma_cond_eval
    import dce_pkg::*;
#(
    parameter int ADDR_W       = 4,
    parameter int DATA_W       = 32,
    parameter int CMD_W        = 16,
    parameter int STAT_W       = 8,
    parameter int MASK_LSB     = 16,
    parameter int VAL_LSB      = 0,
    parameter int IRQ_SEL_IDX  = 4,
    parameter int BR_SEL_IDX   = 5,
    parameter int WAIT_SEL_IDX = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr_en,
    input  logic [ADDR_W-1:0] sel_wr_idx,
    input  logic [DATA_W-1:0] sel_wr_data,
    input  logic [ADDR_W-1:0] sel_rd_idx,
    output logic [DATA_W-1:0] sel_rd_data,
    input  logic              eval_strobe,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic [STAT_W-1:0] dev_status,
    output logic              result_valid,
    output logic              irq_pulse,
    output logic              branch_take,
    output logic              step_next,
    output logic              wait_stall
);
    // Mode field of unit u starts at bit MODE_TOP_LSB - 2*u.
    localparam int MODE_W       = 2;
    localparam int MODE_TOP_LSB = MODE_W * (N_UNITS - 1);

    sel_t [N_UNITS-1:0] sel;
    logic [N_UNITS-1:0] fire;
    logic [N_UNITS-1:0] fire_q;
    logic               valid_q;

    dce_sel_regs #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .MASK_LSB    (MASK_LSB),
        .VAL_LSB     (VAL_LSB),
        .IRQ_SEL_IDX (IRQ_SEL_IDX),
        .BR_SEL_IDX  (BR_SEL_IDX),
        .WAIT_SEL_IDX(WAIT_SEL_IDX)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (sel_wr_en),
        .wr_idx (sel_wr_idx),
        .wr_data(sel_wr_data),
        .rd_idx (sel_rd_idx),
        .rd_data(sel_rd_data),
        .sel_o  (sel)
    );

    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        dce_cond_unit u_cond (
            .sel_i   (sel[u]),
            .status_i(dev_status[COND_W-1:0]),
            .mode_i  (gate_mode_e'(cmd_word[MODE_TOP_LSB - MODE_W*u +: MODE_W])),
            .fire_o  (fire[u])
        );
    end

    // Register the decisions only for the cycle after an evaluate strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            fire_q  <= '0;
        end else begin
            valid_q <= eval_strobe;
            fire_q  <= eval_strobe ? fire : '0;
        end
    end

    assign result_valid = valid_q;
    assign irq_pulse    = fire_q[UNIT_IRQ];
    assign branch_take  = fire_q[UNIT_BR];
    assign step_next    = valid_q && !fire_q[UNIT_BR];
    assign wait_stall   = fire_q[UNIT_WAIT];

    AST_IRQ_NEEDS_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(eval_strobe)); // R8

    AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse && !eval_strobe) |=> !irq_pulse); // R5

    AST_BRANCH_XOR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $countones({branch_take, step_next}) == 1); // R6

    AST_STEP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> !(branch_take || step_next || wait_stall || irq_pulse)); // R8

    AST_IRQ_NEVER_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_strobe && cmd_word[5:4] == 2'b00) |=> !irq_pulse); // R5

    AST_WAIT_ALWAYS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_strobe && cmd_word[1:0] == 2'b11) |=> wait_stall); // R7

    AST_BRANCH_NEVER_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_strobe && cmd_word[3:2] == 2'b00) |=> step_next); // R6
endmodule

// File: tb/dma_cond_eval_tb_top.sv
// Bench: behavioural reference model compared on every clock, plus directed
// cases for reset, field positions, ignored writes and same-cycle ordering.
module dma_cond_eval_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sel_wr_en;
    logic [3:0]  sel_wr_idx;
    logic [31:0] sel_wr_data;
    logic [3:0]  sel_rd_idx;
    logic [31:0] sel_rd_data;
    logic        eval_strobe;
    logic [15:0] cmd_word;
    logic [7:0]  dev_status;
    logic        result_valid, irq_pulse, branch_take, step_next, wait_stall;

    int n_chk = 0;
    int n_fail = 0;
    bit compare_on = 0;
    bit done = 0;

    // Reference model state
    int m_mask [3];
    int m_val  [3];
    int idx_tab [3] = '{4, 5, 6};
    bit e_valid, e_irq, e_br, e_wait;

    always #5 clk = ~clk;

    dma_cond_eval dut_i (
        .clk(clk), .rst_n(rst_n),
        .sel_wr_en(sel_wr_en), .sel_wr_idx(sel_wr_idx), .sel_wr_data(sel_wr_data),
        .sel_rd_idx(sel_rd_idx), .sel_rd_data(sel_rd_data),
        .eval_strobe(eval_strobe), .cmd_word(cmd_word), .dev_status(dev_status),
        .result_valid(result_valid), .irq_pulse(irq_pulse),
        .branch_take(branch_take), .step_next(step_next), .wait_stall(wait_stall)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit gate(input int mode, input int u, input int st);
        bit m;
        m = ((st & m_mask[u]) == (m_val[u] & m_mask[u]));
        return (mode == 3) || (mode == 1 && m) || (mode == 2 && !m);
    endfunction

    function automatic int readback(input int idx);
        for (int u = 0; u < 3; u++)
            if (idx == idx_tab[u]) return (m_mask[u] << 16) | m_val[u];
        return 0;
    endfunction

    // Model update at each rising edge: results first, then register writes.
    always @(posedge clk) begin
        if (!rst_n) begin
            e_valid = 0; e_irq = 0; e_br = 0; e_wait = 0;
            for (int u = 0; u < 3; u++) begin m_mask[u] = 0; m_val[u] = 0; end
        end else begin
            e_valid = eval_strobe;
            e_irq  = eval_strobe && gate((cmd_word >> 4) & 3, 0, dev_status & 15);
            e_br   = eval_strobe && gate((cmd_word >> 2) & 3, 1, dev_status & 15);
            e_wait = eval_strobe && gate(cmd_word & 3, 2, dev_status & 15);
            if (sel_wr_en)
                for (int u = 0; u < 3; u++)
                    if (sel_wr_idx == idx_tab[u]) begin
                        m_mask[u] = (sel_wr_data >> 16) & 15;
                        m_val[u]  = sel_wr_data & 15;
                    end
        end
    end

    // Compare all outputs against the model shortly after each edge.
    always @(posedge clk) begin
        #3;
        if (compare_on) begin
            chk("R8 result_valid", result_valid, e_valid);
            chk("R5 irq_pulse", irq_pulse, e_irq);
            chk("R6 branch_take", branch_take, e_br);
            chk("R6 step_next", step_next, e_valid && !e_br);
            chk("R7 wait_stall", wait_stall, e_wait);
            chk("R2 sel_rd_data", sel_rd_data, readback(sel_rd_idx));
        end
    end

    task automatic idle();
        sel_wr_en = 0; eval_strobe = 0;
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        idle();
        sel_wr_en = 1; sel_wr_idx = 4'(idx); sel_wr_data = d;
        @(negedge clk);
        idle();
    endtask

    // Evaluate and leave the bench just after the result edge.
    task automatic ev(input logic [15:0] c, input logic [7:0] st);
        @(negedge clk);
        idle();
        eval_strobe = 1; cmd_word = c; dev_status = st;
        @(posedge clk); #3;
    endtask

    initial begin
        rst_n = 0; idle(); sel_wr_idx = 0; sel_wr_data = 0; sel_rd_idx = 4;
        cmd_word = 0; dev_status = 0;
        repeat (3) @(posedge clk);
        #3;
        chk("R1 reset result_valid", result_valid, 0);
        chk("R1 reset irq", irq_pulse | branch_take | step_next | wait_stall, 0);
        chk("R1 reset read sel", sel_rd_data, 0);
        @(negedge clk); rst_n = 1;
        compare_on = 1;

        // R1: zero mask means condition true; mode 1 fires on all units.
        ev(16'h0015, 8'h0A);
        chk("R1 zero-mask irq", irq_pulse, 1);
        chk("R1 zero-mask branch", branch_take, 1);
        chk("R1 zero-mask wait", wait_stall, 1);
        @(negedge clk); idle(); @(posedge clk); #3;
        chk("R8 pulse ends", irq_pulse | result_valid, 0);

        // R2: field positions
        wr(4, 32'hABC5_F0F9);
        sel_rd_idx = 4; #1;
        chk("R2 readback fields", sel_rd_data, 32'h0005_0009);

        // R3: writes to other indices ignored
        wr(7, 32'hFFFF_FFFF);
        wr(0, 32'hFFFF_FFFF);
        sel_rd_idx = 4; #1;
        chk("R3 sel kept", sel_rd_data, 32'h0005_0009);
        sel_rd_idx = 7; #1;
        chk("R3 other read zero", sel_rd_data, 0);

        // R4: mask 3 value 1; upper status bits ignored
        wr(4, 32'h0003_0001);
        ev(16'h0010, 8'hF1);
        chk("R4 true with upper bits", irq_pulse, 1);
        ev(16'h0010, 8'h02);
        chk("R4 false mode1", irq_pulse, 0);
        ev(16'h0020, 8'h06);
        chk("R5 false mode2", irq_pulse, 1);

        // R6: branch mode 2 with condition true -> step
        wr(5, 32'h000F_0007);
        ev(16'h0008, 8'h07);
        chk("R6 branch-false step", step_next, 1);
        ev(16'h0004, 8'h07);
        chk("R6 branch-true take", branch_take, 1);

        // R9: same-cycle write does not affect this evaluate
        wr(4, 32'h000F_0000);
        @(negedge clk); idle();
        eval_strobe = 1; cmd_word = 16'h0010; dev_status = 8'h05;
        sel_wr_en = 1; sel_wr_idx = 4; sel_wr_data = 32'h000F_0005;
        @(posedge clk); #3;
        chk("R9 old select used", irq_pulse, 0);
        ev(16'h0010, 8'h05);
        chk("R9 new select next", irq_pulse, 1);

        // Random sweep checked by the model
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            eval_strobe = ($urandom % 2) == 0;
            cmd_word    = 16'($urandom);
            dev_status  = 8'($urandom);
            sel_wr_en   = ($urandom % 4) == 0;
            sel_wr_idx  = 4'($urandom % 9);
            sel_wr_data = $urandom;
            sel_rd_idx  = 4'($urandom % 9);
        end
        @(negedge clk); idle();
        repeat (2) @(posedge clk);
        #4;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule